// File: doc/BRIEF.md
# Bank Row and Timing Tracker

This block keeps the per-bank view of one DRAM rank for a memory controller's scheduler. For every bank it remembers which row is open, or that none is. It also holds three absolute cycle stamps: the first cycle at which a column command, a precharge and an activate may go to that bank. Rank-wide, it keeps a short history of recent activate times, so that it can enforce the minimum spacing between activates and a cap on the number of activates inside a sliding window. It also remembers the last column command, so that it can enforce column-to-column spacing.

A scheduler uses the block in two ways. First, it sets a query bank and row and reads back, in the same cycle, whether that row is open (a hit) and whether an activate, a column command or a precharge would be legal now. Second, it issues commands on the command port. A legal command updates the state at the clock edge. A command that breaks a rule changes nothing and sets a sticky error flag. The block also reports how many banks have an open row and, for the queried bank, how many column accesses and bytes have been served since its row was opened.

Top module: `bank_timing_tracker`

## Requirements
- R1: Each bank holds an open-row value; the all-ones row value means no row is open. `q_open_row` shows the queried bank's value. `q_hit` is 1 exactly when that bank has a row open and it equals `q_row`.
- R2: After reset every bank is closed, no timing restriction is pending, `active_banks` is 0 and `err_flag` is 0.
- R3: A column command (op 1 = read, op 2 = write) is legal only if all of the following hold. The bank has a row open and it equals the command row. At least T_RCD cycles have passed since that bank's activate. At least T_CCD_L cycles have passed since the previous column command in the same bank group, or T_BURST cycles if that command was in a different group.
- R4: A precharge (op 3) is legal only if all of the following hold. The bank has a row open. At least T_RAS cycles have passed since its activate. At least T_RTP cycles have passed since its last read. At least T_WR cycles have passed since its last write.
- R5: An activate (op 0) is legal only if all of the following hold. The bank is closed. The row is not all-ones. At least T_RP cycles have passed since the bank's precharge. At least T_RRD cycles have passed since the previous activate in the rank, or T_RRD_L cycles if that activate was in the same bank group and groups are enabled. The group of a bank is its index divided by NUM_BANKS/NUM_GROUPS.
- R6: No more than ACT_LIMIT activates may fall inside a window of T_XAW cycles. An activate at cycle t is legal only if t is at least T_XAW after the activate issued ACT_LIMIT activates before it.
- R7: `active_banks` goes up by one on every legal activate and down by one on every legal precharge.
- R8: A legal activate clears the bank's access count and byte count. Each legal read or write adds 1 to the access count and BURST_BYTES to the byte count.
- R9: A command that breaks R3 to R6 sets `err_flag`, which stays at 1 until reset. Such a command changes no bank, history or count state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_row | input | ROW_W | Row for activate or column command |
| q_bank | input | BANK_W | Bank being queried |
| q_row | input | ROW_W | Row being queried |
| q_open_row | output | ROW_W | Open row of the queried bank, all-ones if closed |
| q_hit | output | 1 | Queried row is open in the queried bank |
| q_act_ok | output | 1 | Activate of q_row to q_bank legal now |
| q_col_ok | output | 1 | Column command to q_bank/q_row legal now |
| q_pre_ok | output | 1 | Precharge of q_bank legal now |
| q_accesses | output | CNT_W | Column accesses since the queried bank opened |
| q_bytes | output | BYTE_W | Bytes served since the queried bank opened |
| active_banks | output | CNTB_W | Number of banks with an open row |
| err_flag | output | 1 | Sticky illegal-command flag |

## Verification
The bound assertions check on every cycle how the active-bank count steps on legal activates and precharges. They also check that the count stays within range, that the error flag is sticky, that it rises only after an illegal command, and that a precharge is never offered for a closed bank. Only the bench scenarios can show the timing windows themselves. These are the exact first cycle at which a column, a precharge or an activate becomes legal, the longer spacing inside a bank group, the activate that waits for the oldest stamp to leave the window, and the access and byte counters. The bench compares all of these every cycle against its own model under directed sequences and seeded random traffic.

// File: rtl/btt_pkg.sv
package btt_pkg;
   typedef enum logic [1:0] {
      OP_ACT = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2,
      OP_PRE = 2'd3
   } btt_op_e;
endpackage

// File: rtl/btt_bank.sv
module btt_bank #(
   parameter int ROW_W       = 14,
   parameter int TIME_W      = 32,
   parameter int CNT_W       = 16,
   parameter int BYTE_W      = 22,
   parameter int T_RCD       = 4,
   parameter int T_RAS       = 10,
   parameter int T_RP        = 4,
   parameter int T_RTP       = 3,
   parameter int T_WR        = 6,
   parameter int BURST_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic              act_en,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              pre_en,
   input  logic [ROW_W-1:0]  row_in,
   output logic [ROW_W-1:0]  open_row,
   output logic [TIME_W-1:0] col_at,
   output logic [TIME_W-1:0] pre_at,
   output logic [TIME_W-1:0] act_at,
   output logic [CNT_W-1:0]  accesses,
   output logic [BYTE_W-1:0] bytes
);
   localparam logic [TIME_W-1:0] D_RCD = TIME_W'(T_RCD);
   localparam logic [TIME_W-1:0] D_RAS = TIME_W'(T_RAS);
   localparam logic [TIME_W-1:0] D_RP  = TIME_W'(T_RP);
   localparam logic [TIME_W-1:0] D_RTP = TIME_W'(T_RTP);
   localparam logic [TIME_W-1:0] D_WR  = TIME_W'(T_WR);
   localparam logic [BYTE_W-1:0] D_BB  = BYTE_W'(BURST_BYTES);

   logic [TIME_W-1:0] col_recover;

   // precharge bound set by this column command
   always_comb col_recover = rd_en ? now + D_RTP : now + D_WR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_row <= '1;
         col_at   <= '0;
         pre_at   <= '0;
         act_at   <= '0;
         accesses <= '0;
         bytes    <= '0;
      end else if (act_en) begin
         open_row <= row_in;
         col_at   <= now + D_RCD;
         pre_at   <= now + D_RAS;
         accesses <= '0;
         bytes    <= '0;
      end else if (rd_en || wr_en) begin
         accesses <= accesses + 1'b1;
         bytes    <= bytes + D_BB;
         if (col_recover > pre_at) pre_at <= col_recover;
      end else if (pre_en) begin
         open_row <= '1;
         act_at   <= now + D_RP;
      end
   end
endmodule

// File: rtl/btt_spacing.sv
module btt_spacing #(
   parameter int TIME_W    = 32,
   parameter int GRP_W     = 1,
   parameter int ACT_LIMIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic              act_en,
   input  logic [GRP_W-1:0]  act_grp,
   input  logic              col_en,
   input  logic [GRP_W-1:0]  col_grp,
   output logic [TIME_W-1:0] last_act_t,
   output logic [GRP_W-1:0]  last_act_grp,
   output logic              act_seen,
   output logic [TIME_W-1:0] oldest_t,
   output logic              hist_full,
   output logic [TIME_W-1:0] last_col_t,
   output logic [GRP_W-1:0]  last_col_grp,
   output logic              col_seen
);
   logic [TIME_W-1:0] stamp [ACT_LIMIT];
   logic              used  [ACT_LIMIT];

   // activate history: slot 0 newest, last slot oldest
   for (genvar i = 0; i < ACT_LIMIT; i++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stamp[i] <= '0;
            used[i]  <= 1'b0;
         end else if (act_en) begin
            if (i == 0) begin
               stamp[i] <= now;
               used[i]  <= 1'b1;
            end else begin
               stamp[i] <= stamp[(i == 0) ? 0 : i-1];
               used[i]  <= used[(i == 0) ? 0 : i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_act_grp <= '0;
         last_col_t   <= '0;
         last_col_grp <= '0;
         col_seen     <= 1'b0;
      end else begin
         if (act_en) last_act_grp <= act_grp;
         if (col_en) begin
            last_col_t   <= now;
            last_col_grp <= col_grp;
            col_seen     <= 1'b1;
         end
      end
   end

   assign last_act_t = stamp[0];
   assign act_seen   = used[0];
   assign oldest_t   = stamp[ACT_LIMIT-1];
   assign hist_full  = used[ACT_LIMIT-1];
endmodule

// File: rtl/btt_rules.sv
module btt_rules #(
   parameter int ROW_W   = 14,
   parameter int TIME_W  = 32,
   parameter int GRP_W   = 1,
   parameter bit BG_EN   = 1'b1,
   parameter int T_RRD   = 2,
   parameter int T_RRD_L = 3,
   parameter int T_XAW   = 16,
   parameter int T_CCD_L = 3,
   parameter int T_BURST = 2
) (
   input  logic [TIME_W-1:0] now,
   input  logic [ROW_W-1:0]  open_row,
   input  logic [TIME_W-1:0] col_at,
   input  logic [TIME_W-1:0] pre_at,
   input  logic [TIME_W-1:0] act_at,
   input  logic [ROW_W-1:0]  row,
   input  logic [GRP_W-1:0]  grp,
   input  logic [TIME_W-1:0] last_act_t,
   input  logic [GRP_W-1:0]  last_act_grp,
   input  logic              act_seen,
   input  logic [TIME_W-1:0] oldest_t,
   input  logic              hist_full,
   input  logic [TIME_W-1:0] last_col_t,
   input  logic [GRP_W-1:0]  last_col_grp,
   input  logic              col_seen,
   output logic              hit,
   output logic              act_ok,
   output logic              col_ok,
   output logic              pre_ok
);
   localparam logic [TIME_W-1:0] D_RRD   = TIME_W'(T_RRD);
   localparam logic [TIME_W-1:0] D_RRD_L = TIME_W'(T_RRD_L);
   localparam logic [TIME_W-1:0] D_XAW   = TIME_W'(T_XAW);
   localparam logic [TIME_W-1:0] D_CCD_L = TIME_W'(T_CCD_L);
   localparam logic [TIME_W-1:0] D_BURST = TIME_W'(T_BURST);

   logic same_act, same_col, is_open, rrd_ok, xaw_ok, ccd_ok;

   if (BG_EN) begin : g_groups
      assign same_act = (grp == last_act_grp);
      assign same_col = (grp == last_col_grp);
   end else begin : g_flat
      assign same_act = 1'b0;
      assign same_col = 1'b0;
   end

   always_comb begin
      is_open = (open_row != '1);
      hit     = is_open && (open_row == row);
      rrd_ok  = !act_seen || (now >= last_act_t + (same_act ? D_RRD_L : D_RRD));
      xaw_ok  = !hist_full || (now >= oldest_t + D_XAW);
      ccd_ok  = !col_seen || (now >= last_col_t + (same_col ? D_CCD_L : D_BURST));
      act_ok  = !is_open && (row != '1) && (now >= act_at) && rrd_ok && xaw_ok;
      col_ok  = hit && (now >= col_at) && ccd_ok;
      pre_ok  = is_open && (now >= pre_at);
   end
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker #(
   parameter int NUM_BANKS   = 8,
   parameter int NUM_GROUPS  = 2,
   parameter bit BG_EN       = 1'b1,
   parameter int ROW_W       = 14,
   parameter int TIME_W      = 32,
   parameter int CNT_W       = 16,
   parameter int BURST_BYTES = 64,
   parameter int ACT_LIMIT   = 4,
   parameter int T_RCD       = 4,
   parameter int T_RAS       = 10,
   parameter int T_RP        = 4,
   parameter int T_RTP       = 3,
   parameter int T_WR        = 6,
   parameter int T_RRD       = 2,
   parameter int T_RRD_L     = 3,
   parameter int T_XAW       = 16,
   parameter int T_CCD_L     = 3,
   parameter int T_BURST     = 2,
   localparam int BANK_W     = $clog2(NUM_BANKS),
   localparam int BYTE_W     = CNT_W + $clog2(BURST_BYTES),
   localparam int CNTB_W     = $clog2(NUM_BANKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_W-1:0]  cmd_row,
   input  logic [BANK_W-1:0] q_bank,
   input  logic [ROW_W-1:0]  q_row,
   output logic [ROW_W-1:0]  q_open_row,
   output logic              q_hit,
   output logic              q_act_ok,
   output logic              q_col_ok,
   output logic              q_pre_ok,
   output logic [CNT_W-1:0]  q_accesses,
   output logic [BYTE_W-1:0] q_bytes,
   output logic [CNTB_W-1:0] active_banks,
   output logic              err_flag
);
   import btt_pkg::*;

   localparam int GRP_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
   localparam int PER_GRP  = NUM_BANKS / NUM_GROUPS;

   if ((1 << BANK_W) != NUM_BANKS || NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (NUM_GROUPS < 1 || (NUM_BANKS % NUM_GROUPS) != 0) begin : g_bad_groups
      $error("NUM_GROUPS must divide NUM_BANKS");
   end
   if (ACT_LIMIT < 1 || T_RRD_L < T_RRD || ROW_W < 2) begin : g_bad_timing
      $error("illegal timing or width parameters");
   end

   function automatic logic [GRP_W-1:0] grp_of(input logic [BANK_W-1:0] b);
      return GRP_W'(int'(b) / PER_GRP);
   endfunction

   logic [TIME_W-1:0] now;
   btt_op_e           op;
   logic              cmd_legal;

   logic [ROW_W-1:0]  b_row   [NUM_BANKS];
   logic [TIME_W-1:0] b_col   [NUM_BANKS];
   logic [TIME_W-1:0] b_pre   [NUM_BANKS];
   logic [TIME_W-1:0] b_act   [NUM_BANKS];
   logic [CNT_W-1:0]  b_acc   [NUM_BANKS];
   logic [BYTE_W-1:0] b_bytes [NUM_BANKS];

   logic [TIME_W-1:0] last_act_t, oldest_t, last_col_t;
   logic [GRP_W-1:0]  last_act_grp, last_col_grp;
   logic              act_seen, hist_full, col_seen;
   logic              c_hit, c_act_ok, c_col_ok, c_pre_ok;
   logic              do_act, do_col;

   assign op = btt_op_e'(cmd_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic sel;
      assign sel = cmd_legal && (cmd_bank == BANK_W'(i));
      btt_bank #(
         .ROW_W(ROW_W), .TIME_W(TIME_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W),
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RTP(T_RTP),
         .T_WR(T_WR), .BURST_BYTES(BURST_BYTES)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .now(now),
         .act_en(sel && op == OP_ACT), .rd_en(sel && op == OP_RD),
         .wr_en(sel && op == OP_WR),   .pre_en(sel && op == OP_PRE),
         .row_in(cmd_row), .open_row(b_row[i]), .col_at(b_col[i]),
         .pre_at(b_pre[i]), .act_at(b_act[i]), .accesses(b_acc[i]),
         .bytes(b_bytes[i])
      );
   end

   assign do_act = cmd_legal && op == OP_ACT;
   assign do_col = cmd_legal && (op == OP_RD || op == OP_WR);

   btt_spacing #(.TIME_W(TIME_W), .GRP_W(GRP_W), .ACT_LIMIT(ACT_LIMIT)) u_space (
      .clk(clk), .rst_n(rst_n), .now(now),
      .act_en(do_act), .act_grp(grp_of(cmd_bank)),
      .col_en(do_col), .col_grp(grp_of(cmd_bank)),
      .last_act_t(last_act_t), .last_act_grp(last_act_grp), .act_seen(act_seen),
      .oldest_t(oldest_t), .hist_full(hist_full),
      .last_col_t(last_col_t), .last_col_grp(last_col_grp), .col_seen(col_seen)
   );

   // one rule set answers the query port, a second judges the command
   btt_rules #(
      .ROW_W(ROW_W), .TIME_W(TIME_W), .GRP_W(GRP_W), .BG_EN(BG_EN),
      .T_RRD(T_RRD), .T_RRD_L(T_RRD_L), .T_XAW(T_XAW),
      .T_CCD_L(T_CCD_L), .T_BURST(T_BURST)
   ) u_qrules (
      .now(now), .open_row(b_row[q_bank]), .col_at(b_col[q_bank]),
      .pre_at(b_pre[q_bank]), .act_at(b_act[q_bank]),
      .row(q_row), .grp(grp_of(q_bank)),
      .last_act_t(last_act_t), .last_act_grp(last_act_grp), .act_seen(act_seen),
      .oldest_t(oldest_t), .hist_full(hist_full),
      .last_col_t(last_col_t), .last_col_grp(last_col_grp), .col_seen(col_seen),
      .hit(q_hit), .act_ok(q_act_ok), .col_ok(q_col_ok), .pre_ok(q_pre_ok)
   );

   btt_rules #(
      .ROW_W(ROW_W), .TIME_W(TIME_W), .GRP_W(GRP_W), .BG_EN(BG_EN),
      .T_RRD(T_RRD), .T_RRD_L(T_RRD_L), .T_XAW(T_XAW),
      .T_CCD_L(T_CCD_L), .T_BURST(T_BURST)
   ) u_crules (
      .now(now), .open_row(b_row[cmd_bank]), .col_at(b_col[cmd_bank]),
      .pre_at(b_pre[cmd_bank]), .act_at(b_act[cmd_bank]),
      .row(cmd_row), .grp(grp_of(cmd_bank)),
      .last_act_t(last_act_t), .last_act_grp(last_act_grp), .act_seen(act_seen),
      .oldest_t(oldest_t), .hist_full(hist_full),
      .last_col_t(last_col_t), .last_col_grp(last_col_grp), .col_seen(col_seen),
      .hit(c_hit), .act_ok(c_act_ok), .col_ok(c_col_ok), .pre_ok(c_pre_ok)
   );

   always_comb begin
      unique case (op)
         OP_ACT:       cmd_legal = cmd_valid && c_act_ok;
         OP_RD, OP_WR: cmd_legal = cmd_valid && c_col_ok && c_hit;
         default:      cmd_legal = cmd_valid && c_pre_ok;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_banks <= '0;
         err_flag     <= 1'b0;
      end else begin
         if (cmd_valid && !cmd_legal) err_flag <= 1'b1;
         if (do_act)                             active_banks <= active_banks + 1'b1;
         else if (cmd_legal && op == OP_PRE)     active_banks <= active_banks - 1'b1;
      end
   end

   assign q_open_row = b_row[q_bank];
   assign q_accesses = b_acc[q_bank];
   assign q_bytes    = b_bytes[q_bank];
endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 14,
   parameter int CNTB_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic              cmd_legal,
   input logic [CNTB_W-1:0] active_banks,
   input logic              err_flag,
   input logic              q_pre_ok,
   input logic [ROW_W-1:0]  q_open_row
);
   // R9: the error flag never clears once set
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R9: the flag rises only after a rejected command
   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(cmd_valid && !cmd_legal));

   // R9: a rejected command leaves the open-bank count alone
   a_r9_no_count_change: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_legal) |=> $stable(active_banks));

   // R7: legal activate adds one open bank
   a_r7_act_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_legal && cmd_op == 2'd0) |=>
         active_banks == CNTB_W'($past(active_banks) + 1'b1));

   // R7: legal precharge removes one open bank
   a_r7_pre_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_legal && cmd_op == 2'd3) |=>
         active_banks == CNTB_W'($past(active_banks) - 1'b1));

   // R7: the count never exceeds the bank total
   a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      active_banks <= CNTB_W'(NUM_BANKS));

   // R4: precharge is only offered for an open bank
   a_r4_pre_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
      q_pre_ok |-> q_open_row != '1);
endmodule

bind bank_timing_tracker btt_checker #(
   .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CNTB_W(CNTB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_legal(cmd_legal), .active_banks(active_banks), .err_flag(err_flag),
   .q_pre_ok(q_pre_ok), .q_open_row(q_open_row)
);

// File: tb/sim_bank_timing_tracker.sv
module sim_bank_timing_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 8, NG = 2, ROW_W = 14, CNT_W = 16, BB = 64, LIM = 4;
   localparam int RCD = 4, RAS = 10, RP = 4, RTP = 3, WR = 6;
   localparam int RRD = 2, RRD_L = 3, XAW = 16, CCD_L = 3, BST = 2;
   localparam int BANK_W = 3, BYTE_W = CNT_W + 6, CNTB_W = 4;
   localparam int NONE = (1 << ROW_W) - 1;

   logic clk = 0, rst_n = 0, cmd_valid = 0;
   logic [1:0] cmd_op = 0;
   logic [BANK_W-1:0] cmd_bank = 0, q_bank = 0;
   logic [ROW_W-1:0] cmd_row = 0, q_row = 0;
   logic [ROW_W-1:0] q_open_row;
   logic q_hit, q_act_ok, q_col_ok, q_pre_ok, err_flag;
   logic [CNT_W-1:0] q_accesses;
   logic [BYTE_W-1:0] q_bytes;
   logic [CNTB_W-1:0] active_banks;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_timing_tracker #(
      .NUM_BANKS(NB), .NUM_GROUPS(NG), .BG_EN(1'b1), .ROW_W(ROW_W), .TIME_W(32),
      .CNT_W(CNT_W), .BURST_BYTES(BB), .ACT_LIMIT(LIM), .T_RCD(RCD), .T_RAS(RAS),
      .T_RP(RP), .T_RTP(RTP), .T_WR(WR), .T_RRD(RRD), .T_RRD_L(RRD_L),
      .T_XAW(XAW), .T_CCD_L(CCD_L), .T_BURST(BST)
   ) u0 (.*);

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   // bench model of the rank
   longint m_now;
   int     m_row [NB];
   longint m_col_at [NB], m_pre_at [NB], m_act_at [NB];
   int     m_acc [NB], m_bytes [NB];
   longint m_hist [LIM];
   int     m_nact, m_lastb, m_lastcb, m_active;
   bit     m_ncol, m_err;
   longint m_last_col;

   task automatic check(string req, string what, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int grp(int b); return b / (NB / NG); endfunction

   function automatic bit m_act_ok(int b, int r);
      int gap;
      if (m_row[b] != NONE || r == NONE || m_now < m_act_at[b]) return 0;
      gap = (grp(b) == grp(m_lastb)) ? RRD_L : RRD;
      if (m_nact > 0 && m_now < m_hist[0] + gap) return 0;
      if (m_nact >= LIM && m_now < m_hist[LIM-1] + XAW) return 0;
      return 1;
   endfunction

   function automatic bit m_col_ok(int b, int r);
      int gap;
      if (m_row[b] == NONE || m_row[b] != r || m_now < m_col_at[b]) return 0;
      gap = (grp(b) == grp(m_lastcb)) ? CCD_L : BST;
      if (m_ncol && m_now < m_last_col + gap) return 0;
      return 1;
   endfunction

   function automatic bit m_pre_ok(int b);
      return m_row[b] != NONE && m_now >= m_pre_at[b];
   endfunction

   function automatic bit m_ok(int op, int b, int r);
      case (op)
         0: return m_act_ok(b, r);
         1, 2: return m_col_ok(b, r);
         default: return m_pre_ok(b);
      endcase
   endfunction

   function automatic void m_reset();
      m_now = 0; m_nact = 0; m_lastb = 0; m_lastcb = 0; m_active = 0;
      m_ncol = 0; m_err = 0; m_last_col = 0;
      for (int i = 0; i < NB; i++) begin
         m_row[i] = NONE; m_col_at[i] = 0; m_pre_at[i] = 0; m_act_at[i] = 0;
         m_acc[i] = 0; m_bytes[i] = 0;
      end
      for (int i = 0; i < LIM; i++) m_hist[i] = 0;
   endfunction

   function automatic void m_apply(int op, int b, int r);
      longint t = m_now;
      case (op)
         0: begin
            m_row[b] = r; m_col_at[b] = t + RCD; m_pre_at[b] = t + RAS;
            m_acc[b] = 0; m_bytes[b] = 0;
            for (int i = LIM-1; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = t; m_lastb = b;
            if (m_nact < LIM) m_nact++;
            m_active++;
         end
         1, 2: begin
            m_acc[b]++; m_bytes[b] += BB;
            if (t + ((op == 1) ? RTP : WR) > m_pre_at[b]) m_pre_at[b] = t + ((op == 1) ? RTP : WR);
            m_ncol = 1; m_last_col = t; m_lastcb = b;
         end
         default: begin
            m_row[b] = NONE; m_act_at[b] = t + RP; m_active--;
         end
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 0; cmd_valid = 0;
      repeat (2) @(posedge clk);
      m_reset();
      @(negedge clk); rst_n = 1;
   endtask

   // one cycle: drive, compare every output to the model, then step the model
   task automatic step(bit v, int op, int b, int r);
      bit legal;
      @(negedge clk);
      cmd_valid = v; cmd_op = 2'(op); cmd_bank = BANK_W'(b); cmd_row = ROW_W'(r);
      q_bank = BANK_W'(b); q_row = ROW_W'(r);
      #1;
      check("R1", "open row", q_open_row, m_row[b]);
      check("R1", "hit", q_hit, (m_row[b] != NONE && m_row[b] == r));
      check("R5/R6", "act_ok", q_act_ok, m_act_ok(b, r));
      check("R3", "col_ok", q_col_ok, m_col_ok(b, r));
      check("R4", "pre_ok", q_pre_ok, m_pre_ok(b));
      check("R8", "accesses", q_accesses, m_acc[b]);
      check("R8", "bytes", q_bytes, m_bytes[b]);
      check("R7", "active banks", active_banks, m_active);
      check("R9", "err flag", err_flag, m_err);
      legal = v && m_ok(op, b, r);
      @(posedge clk);
      if (v && !legal) m_err = 1;
      if (legal) m_apply(op, b, r);
      m_now++;
   endtask

   // issue as soon as the model allows it; returns the issue cycle
   task automatic issue(int op, int b, int r, output longint t_issued);
      t_issued = -1;
      for (int k = 0; k < 200; k++) begin
         if (m_ok(op, b, r)) begin
            t_issued = m_now;
            step(1, op, b, r);
            break;
         end
         step(0, op, b, r);
      end
   endtask

   initial begin
      longint t0, t1, t2, t3, t4;
      int a_before;
      void'($urandom(32'd1234));
      m_reset();
      do_reset();
      #1;
      check("R2", "active after reset", active_banks, 0);
      check("R2", "err after reset", err_flag, 0);
      for (int b = 0; b < NB; b++) step(0, 3, b, 0);

      // R5: same-group spacing uses the long gap, other group the short one
      issue(0, 0, 5, t0);
      issue(0, 1, 2, t1);
      check("R5", "same-group act gap", t1 - t0, RRD_L);
      issue(0, 4, 7, t2);
      check("R5", "cross-group act gap", t2 - t1, RRD);
      // R6: fourth then fifth activate waits for the window
      issue(0, 5, 1, t3);
      issue(0, 2, 3, t4);
      check("R6", "fifth act waits for window", t4, t0 + XAW);
      // R3 / R8: reads after activate
      issue(1, 0, 5, t1);
      check("R3", "first column after act", (t1 >= t0 + RCD), 1);
      issue(2, 0, 5, t2);
      check("R3", "same-group column gap", t2 - t1, CCD_L);
      step(0, 1, 0, 5);
      check("R8", "two accesses counted", q_accesses, 2);
      // R4: precharge waits for write recovery
      issue(3, 0, 5, t3);
      check("R4", "pre after write recovery", t3, t2 + WR);
      // R9: illegal activate to an open bank is dropped
      a_before = m_active;
      step(1, 0, 1, 9);
      step(0, 0, 1, 9);
      check("R9", "illegal act keeps row", q_open_row, 2);
      check("R9", "illegal act keeps count", active_banks, a_before);
      check("R9", "flag set", err_flag, 1);

      // seeded random, legal commands only
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         int op = $urandom_range(0, 3), b = $urandom_range(0, NB-1), r = $urandom_range(0, 3);
         step(m_ok(op, b, r), op, b, r);
      end
      // seeded random including illegal commands and the reserved row value
      do_reset();
      for (int i = 0; i < 2000; i++) begin
         int op = $urandom_range(0, 3), b = $urandom_range(0, NB-1);
         int r = ($urandom_range(0, 31) == 0) ? NONE : $urandom_range(0, 3);
         bit v = m_ok(op, b, r) || ($urandom_range(0, 15) == 0);
         step(v, op, b, r);
      end
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule